// File: doc/BRIEF.md
# Coverage-Weighted Pixel Blend Unit

This unit merges two premultiplied RGBA pixels, a near one and a far one, into a single pixel of the same format. Each pixel arrives with a coverage fraction that gives the share of the pixel owned by the near contribution, and with the depth value already chosen upstream. The unit derives one weight for each side from the two alphas and the coverage. Each colour channel is then the sum of the two weighted colours, and the result alpha is the union of the two alphas.

Work is paced in fixed slots of six clock cycles. One pulse on `in_load` latches a full pixel pair. Two shared multipliers carry out all nine products in that slot. In the next slot the merged pixel leaves as six bytes on one byte-wide output, while the following pair is being computed. Inside the unit, alpha is held in a 9-bit form in which 256 is exactly one, so a fully opaque 8-bit alpha of 255 acts as a true unit factor.

Top module: `pxc_blend`

## Requirements
- R1: While reset is asserted, and after it until the first result is emitted, `out_valid` and `out_first` are 0 and `out_byte` is 0.
- R2: An 8-bit input alpha with bit 7 set is raised by one into the 9-bit form, where 256 is 1.0. On output, a 9-bit alpha above 128 is lowered by one and then truncated to 8 bits. An input alpha therefore leaves unchanged when the other side has alpha 0.
- R3: The result alpha in 9-bit form is aN + aF − floor(aN·aF/256), where aN and aF are the near and far alphas in 9-bit form.
- R4: The far weight is 256 − floor(aN·c/16). The near weight is 256 − floor(aF·(16−c)/16). Here c is the coverage, in which 16 means 1.0.
- R5: Each colour channel is floor(wFar·colFar/256) + floor(wNear·colNear/256).
- R6: A colour sum above 255 is output as 255.
- R7: `in_cover` is 5 bits with 16 meaning full coverage. Any value above 16 gives the same result as 16.
- R8: A result leaves as six bytes on six consecutive cycles, in this order: depth low byte, depth high byte, alpha, red, green, blue. `out_first` is high only with the depth low byte. The first byte appears after the sixth rising edge that follows the edge sampling `in_load`.
- R9: A load sampled on the last cycle of a computation is accepted. Loads spaced six cycles apart therefore produce an output stream with no gap.
- R10: A load sampled while a computation is in any of its first five cycles is ignored. It changes neither the result in progress nor the number of results.
- R11: A near pixel that is transparent black (zero colour and zero alpha) passes the far pixel through unchanged, whatever the coverage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_load | input | 1 | Latch the pixel pair on this edge when allowed |
| in_depth | input | 16 | Depth value carried to the output |
| in_near_a | input | 8 | Near alpha |
| in_near_r | input | 8 | Near red, premultiplied |
| in_near_g | input | 8 | Near green, premultiplied |
| in_near_b | input | 8 | Near blue, premultiplied |
| in_far_a | input | 8 | Far alpha |
| in_far_r | input | 8 | Far red, premultiplied |
| in_far_g | input | 8 | Far green, premultiplied |
| in_far_b | input | 8 | Far blue, premultiplied |
| in_cover | input | 5 | Near coverage, 16 = 1.0 |
| out_byte | output | 8 | Serial result byte |
| out_valid | output | 1 | `out_byte` carries a result byte |
| out_first | output | 1 | Marks the depth low byte |

## Verification
The assertions check on every cycle that the stored weights and alpha never exceed one, that the latched coverage and its complement always sum to one, that a load arriving mid-slot leaves the latched pixel untouched, and that the byte stream is contiguous with a single leading marker. The exact arithmetic cannot be shown that way: truncation of products, the alpha rescaling round trip, saturation, coverage clamping, the six-edge latency and the gapless back-to-back stream are only visible in the bench's scenarios, which compare every emitted byte with values derived from the formulas.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
    // Slot schedule: one pixel pair per six cycles.
    typedef enum logic [2:0] {
        PH_FACT  = 3'd0,   // both weights
        PH_RED   = 3'd1,
        PH_GRN   = 3'd2,
        PH_BLU   = 3'd3,
        PH_ALPHA = 3'd4,   // alpha product
        PH_DONE  = 3'd5    // hand result to the serializer
    } phase_e;

    localparam int SLOT_CYCLES = 6;
endpackage

// File: rtl/pxc_mul.sv
// Shared unsigned multiplier; product scaled back by one of two shifts.
module pxc_mul #(
    parameter int AW        = 9,
    parameter int SH_WIDE   = 8,
    parameter int SH_NARROW = 4
) (
    input  logic [AW-1:0] x,
    input  logic [AW-1:0] y,
    input  logic          narrow,
    output logic [AW-1:0] p
);
    localparam int PW = 2 * AW;

    logic [PW-1:0] full;
    logic [PW-1:0] scaled;

    assign full   = PW'(x) * PW'(y);
    assign scaled = narrow ? (full >> SH_NARROW) : (full >> SH_WIDE);
    assign p      = scaled[AW-1:0];

    logic unused_hi;
    assign unused_hi = ^scaled[PW-1:AW];
endmodule

// File: rtl/pxc_alpha_cvt.sv
// Alpha rescaling between the 8-bit external and 9-bit internal forms.
module pxc_alpha_cvt #(
    parameter int CW     = 8,
    parameter bit EXPAND = 1'b1
) (
    input  logic [CW:0] din,
    output logic [CW:0] dout
);
    localparam int AW = CW + 1;
    localparam logic [AW-1:0] HALF = AW'(1) << (CW - 1);

    generate
        if (EXPAND) begin : g_up
            logic unused_top;
            assign unused_top = din[CW];
            assign dout = {1'b0, din[CW-1:0]} + AW'(din[CW-1]);
        end else begin : g_down
            assign dout = (din > HALF) ? (din - AW'(1)) : din;
        end
    endgenerate
endmodule

// File: rtl/pxc_emit.sv
// Byte serializer: six bytes per result, lowest byte first.
module pxc_emit #(
    parameter int W  = 8,
    parameter int NB = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NB*W-1:0] din,
    output logic [W-1:0]  out_byte,
    output logic          out_valid,
    output logic          out_first
);
    localparam int OW   = NB * W;
    localparam int CNTW = $clog2(NB);

    typedef struct packed {
        logic [OW-1:0]   sr;
        logic [CNTW-1:0] cnt;
        logic            valid;
    } em_t;

    em_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (e_q.valid) begin
            e_d.sr  = e_q.sr >> W;
            e_d.cnt = e_q.cnt + CNTW'(1);
            if (e_q.cnt == CNTW'(NB - 1)) begin
                e_d.valid = 1'b0;
            end
        end
        if (load) begin
            e_d.sr    = din;
            e_d.cnt   = '0;
            e_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign out_byte  = e_q.valid ? e_q.sr[W-1:0] : '0;
    assign out_valid = e_q.valid;
    assign out_first = e_q.valid && (e_q.cnt == '0);

    // R8: the leading marker never repeats on the next cycle
    assert_first_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |=> !out_first);

    // R8: every byte other than the first continues a running stream
    assert_contig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_first) |-> $past(out_valid));
endmodule

// File: rtl/pxc_blend.sv
module pxc_blend
    import pxc_pkg::*;
#(
    parameter int CW  = 8,
    parameter int ZW  = 16,
    parameter int CVW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_load,
    input  logic [ZW-1:0]  in_depth,
    input  logic [CW-1:0]  in_near_a,
    input  logic [CW-1:0]  in_near_r,
    input  logic [CW-1:0]  in_near_g,
    input  logic [CW-1:0]  in_near_b,
    input  logic [CW-1:0]  in_far_a,
    input  logic [CW-1:0]  in_far_r,
    input  logic [CW-1:0]  in_far_g,
    input  logic [CW-1:0]  in_far_b,
    input  logic [CVW-1:0] in_cover,
    output logic [CW-1:0]  out_byte,
    output logic           out_valid,
    output logic           out_first
);
    localparam int AW  = CW + 1;
    localparam int NCH = 3;
    localparam int ZB  = ZW / CW;
    localparam int NB  = ZB + 1 + NCH;
    localparam logic [AW-1:0]  ONE  = AW'(1) << CW;
    localparam logic [CVW-1:0] CONE = CVW'(1) << (CVW - 1);

    typedef struct packed {
        phase_e                    phase;
        logic                      busy;
        logic [ZW-1:0]             depth;
        logic [AW-1:0]             an;      // near alpha, 9-bit form
        logic [AW-1:0]             af;      // far alpha, 9-bit form
        logic [NCH-1:0][CW-1:0]    cn;
        logic [NCH-1:0][CW-1:0]    cf;
        logic [CVW-1:0]            cov;
        logic [CVW-1:0]            ncov;
        logic [AW-1:0]             wn;      // near weight
        logic [AW-1:0]             wf;      // far weight
        logic [NCH-1:0][CW-1:0]    rgb;
        logic [AW-1:0]             alpha;
    } st_t;

    st_t s_d, s_q;

    // Input alpha expansion
    logic [AW-1:0] an_in, af_in;
    pxc_alpha_cvt #(.CW(CW), .EXPAND(1'b1)) u_cvt_near (
        .din ({1'b0, in_near_a}),
        .dout(an_in)
    );
    pxc_alpha_cvt #(.CW(CW), .EXPAND(1'b1)) u_cvt_far (
        .din ({1'b0, in_far_a}),
        .dout(af_in)
    );

    logic [CVW-1:0] cov_cl;
    assign cov_cl = (in_cover > CONE) ? CONE : in_cover;

    // Operand selection for the two shared multipliers.
    // Multiplier A: near-colour side; multiplier B: far-colour side.
    logic [AW-1:0] opa_x, opa_y, opb_x, opb_y, prod_a, prod_b;
    logic          narrow;
    logic [1:0]    k;

    always_comb begin
        opa_x  = '0;
        opa_y  = '0;
        opb_x  = '0;
        opb_y  = '0;
        narrow = 1'b0;
        unique case (s_q.phase)
            PH_RED:  k = 2'd0;
            PH_GRN:  k = 2'd1;
            PH_BLU:  k = 2'd2;
            default: k = 2'd0;
        endcase
        unique case (s_q.phase)
            PH_FACT: begin
                opa_x  = s_q.af;
                opa_y  = AW'(s_q.ncov);
                opb_x  = s_q.an;
                opb_y  = AW'(s_q.cov);
                narrow = 1'b1;
            end
            PH_RED, PH_GRN, PH_BLU: begin
                opa_x = s_q.wn;
                opa_y = AW'(s_q.cn[k]);
                opb_x = s_q.wf;
                opb_y = AW'(s_q.cf[k]);
            end
            PH_ALPHA: begin
                opa_x = s_q.an;
                opa_y = s_q.af;
            end
            default: ;
        endcase
    end

    pxc_mul #(.AW(AW), .SH_WIDE(CW), .SH_NARROW(CVW - 1)) u_mul_near (
        .x(opa_x), .y(opa_y), .narrow(narrow), .p(prod_a)
    );
    pxc_mul #(.AW(AW), .SH_WIDE(CW), .SH_NARROW(CVW - 1)) u_mul_far (
        .x(opb_x), .y(opb_y), .narrow(narrow), .p(prod_b)
    );

    logic          accept, commit;
    logic [CW:0]   csum;
    logic [CW-1:0] csat;

    assign accept = in_load && (!s_q.busy || (s_q.phase == PH_DONE));
    assign commit = s_q.busy && (s_q.phase == PH_DONE);
    assign csum   = {1'b0, prod_a[CW-1:0]} + {1'b0, prod_b[CW-1:0]};
    assign csat   = csum[CW] ? '1 : csum[CW-1:0];

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            unique case (s_q.phase)
                PH_FACT: begin
                    s_d.wn    = ONE - prod_a;
                    s_d.wf    = ONE - prod_b;
                    s_d.phase = PH_RED;
                end
                PH_RED: begin
                    s_d.rgb[0] = csat;
                    s_d.phase  = PH_GRN;
                end
                PH_GRN: begin
                    s_d.rgb[1] = csat;
                    s_d.phase  = PH_BLU;
                end
                PH_BLU: begin
                    s_d.rgb[2] = csat;
                    s_d.phase  = PH_ALPHA;
                end
                PH_ALPHA: begin
                    s_d.alpha = s_q.an + s_q.af - prod_a;
                    s_d.phase = PH_DONE;
                end
                default: s_d.busy = 1'b0;
            endcase
        end
        if (accept) begin
            s_d.busy  = 1'b1;
            s_d.phase = PH_FACT;
            s_d.depth = in_depth;
            s_d.an    = an_in;
            s_d.af    = af_in;
            s_d.cn    = {in_near_b, in_near_g, in_near_r};
            s_d.cf    = {in_far_b, in_far_g, in_far_r};
            s_d.cov   = cov_cl;
            s_d.ncov  = CONE - cov_cl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Output alpha reduction and serialization
    logic [AW-1:0] alpha_out;
    pxc_alpha_cvt #(.CW(CW), .EXPAND(1'b0)) u_cvt_out (
        .din (s_q.alpha),
        .dout(alpha_out)
    );
    logic unused_aout;
    assign unused_aout = alpha_out[CW];

    pxc_emit #(.W(CW), .NB(NB)) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit),
        .din      ({s_q.rgb, alpha_out[CW-1:0], s_q.depth}),
        .out_byte (out_byte),
        .out_valid(out_valid),
        .out_first(out_first)
    );

    // R3: the stored result alpha never exceeds one
    assert_alpha_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (s_q.alpha <= ONE));

    // R4: both weights stay within [0, 1] once formed
    assert_weight_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.phase != PH_FACT) |-> ((s_q.wn <= ONE) && (s_q.wf <= ONE)));

    // R7: latched coverage is clamped and its complement sums to one
    assert_cover_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> ((s_q.cov <= CONE) && ((s_q.cov + s_q.ncov) == CONE)));

    // R10: a load during the first five slot cycles leaves the latched pixel alone
    assert_load_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.phase != PH_DONE && in_load) |=> ($stable(s_q.depth) && $stable(s_q.cn)));
endmodule

// File: tb/pxc_blend_tb.sv
`timescale 1ns/1ps
module pxc_blend_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_load = 1'b0;
    logic [15:0] in_depth = '0;
    logic [7:0] in_near_a = '0, in_near_r = '0, in_near_g = '0, in_near_b = '0;
    logic [7:0] in_far_a = '0, in_far_r = '0, in_far_g = '0, in_far_b = '0;
    logic [4:0] in_cover = '0;
    logic [7:0] out_byte;
    logic out_valid, out_first;

    always #2.5 clk = ~clk;

    pxc_blend u_dut (
        .clk(clk), .rst_n(rst_n), .in_load(in_load), .in_depth(in_depth),
        .in_near_a(in_near_a), .in_near_r(in_near_r), .in_near_g(in_near_g), .in_near_b(in_near_b),
        .in_far_a(in_far_a), .in_far_r(in_far_r), .in_far_g(in_far_g), .in_far_b(in_far_b),
        .in_cover(in_cover), .out_byte(out_byte), .out_valid(out_valid), .out_first(out_first)
    );

    typedef struct packed {
        logic [15:0] z;
        logic [7:0] na, nr, ng, nb;
        logic [7:0] fa, fr, fg, fb;
        logic [4:0] cov;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h1234, 8'hFF, 8'hC8, 8'h64, 8'h32, 8'hFF, 8'h0A, 8'h14, 8'h1E, 5'd16},
        '{16'hABCD, 8'hFF, 8'hC8, 8'h64, 8'h32, 8'hFF, 8'h0A, 8'h14, 8'h1E, 5'd0},
        '{16'h00FF, 8'h80, 8'h40, 8'h80, 8'h20, 8'hC0, 8'h90, 8'h30, 8'h60, 5'd8},
        '{16'hFF00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h7F, 8'h11, 8'h22, 8'h33, 5'd9},
        '{16'h0001, 8'h40, 8'h30, 8'h10, 8'h3F, 8'h40, 8'h20, 8'h3F, 8'h05, 5'd12},
        '{16'h8000, 8'h00, 8'hFF, 8'hFF, 8'h80, 8'h00, 8'hFF, 8'h01, 8'hFF, 5'd3},
        '{16'h7FFF, 8'h81, 8'h50, 8'h60, 8'h70, 8'h81, 8'h05, 8'h06, 8'h07, 5'd31},
        '{16'h5A5A, 8'h7F, 8'h11, 8'h22, 8'h33, 8'h80, 8'h44, 8'h55, 8'h66, 5'd1}
    };

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            summary();
        end
    end

    // Reference derived from the requirements (R2..R7)
    function automatic logic [47:0] model(input vec_t v);
        int ane, afe, c, nc, wf, wn, a9, ao;
        int ch [3];
        int cn [3];
        int cf [3];
        ane = int'(v.na) + (v.na >= 128 ? 1 : 0);
        afe = int'(v.fa) + (v.fa >= 128 ? 1 : 0);
        c   = (v.cov > 16) ? 16 : int'(v.cov);
        nc  = 16 - c;
        wf  = 256 - ((ane * c) >> 4);
        wn  = 256 - ((afe * nc) >> 4);
        cn = '{int'(v.nr), int'(v.ng), int'(v.nb)};
        cf = '{int'(v.fr), int'(v.fg), int'(v.fb)};
        for (int i = 0; i < 3; i++) begin
            ch[i] = ((wf * cf[i]) >> 8) + ((wn * cn[i]) >> 8);
            if (ch[i] > 255) ch[i] = 255;
        end
        a9 = afe + ane - ((afe * ane) >> 8);
        ao = (a9 > 128) ? a9 - 1 : a9;
        return {8'(ch[2]), 8'(ch[1]), 8'(ch[0]), 8'(ao), v.z};
    endfunction

    task automatic apply(input vec_t v);
        in_depth = v.z;
        in_near_a = v.na; in_near_r = v.nr; in_near_g = v.ng; in_near_b = v.nb;
        in_far_a = v.fa; in_far_r = v.fr; in_far_g = v.fg; in_far_b = v.fb;
        in_cover = v.cov;
        in_load = 1'b1;
    endtask

    // Caller stands just after a falling edge. Load edge follows; bytes sampled
    // after rising edges 6..11 past the load edge.
    task automatic run_one(input vec_t v, output logic [47:0] got, output bit lat_ok);
        bit ok;
        ok = 1'b1;
        @(negedge clk); apply(v);
        @(negedge clk); in_load = 1'b0;
        repeat (5) @(negedge clk);
        if (out_valid) ok = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            got[8*i +: 8] = out_byte;
            if (!out_valid) ok = 1'b0;
            if (out_first != (i == 0)) ok = 1'b0;
        end
        lat_ok = ok;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [47:0] got, exp, got2;
        bit lat_ok;
        vec_t v;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 out_byte in reset", int'(out_byte), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", int'({out_valid, out_first, out_byte}), 0);

        // Table walk
        for (int n = 0; n < NV; n++) begin
            run_one(VECS[n], got, lat_ok);
            exp = model(VECS[n]);
            chk("R8 framing and latency", int'(lat_ok), 1);
            chk("R8 depth low", int'(got[7:0]), int'(exp[7:0]));
            chk("R8 depth high", int'(got[15:8]), int'(exp[15:8]));
            chk("R3 alpha", int'(got[23:16]), int'(exp[23:16]));
            chk("R5 red", int'(got[31:24]), int'(exp[31:24]));
            chk("R5 green", int'(got[39:32]), int'(exp[39:32]));
            chk("R5 blue", int'(got[47:40]), int'(exp[47:40]));
        end

        // R4: weights seen through red (far side) and green (near side)
        v = '{16'h0042, 8'h40, 8'h00, 8'hC8, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 5'd4};
        run_one(v, got, lat_ok);
        chk("R4 far weight via red", int'(got[31:24]), 239);
        chk("R4 near weight via green", int'(got[39:32]), 50);
        chk("R3 opaque union alpha", int'(got[23:16]), 255);

        // R2: alpha round trip with a transparent near side
        v = '{16'h0003, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h02, 8'h03, 5'd5};
        run_one(v, got, lat_ok);
        chk("R2 alpha 128 round trip", int'(got[23:16]), 128);
        v.fa = 8'h7F;
        run_one(v, got, lat_ok);
        chk("R2 alpha 127 round trip", int'(got[23:16]), 127);
        v.fa = 8'hFF;
        run_one(v, got, lat_ok);
        chk("R2 alpha 255 round trip", int'(got[23:16]), 255);

        // R6: saturation (table entry 5)
        run_one(VECS[5], got, lat_ok);
        chk("R6 red saturates", int'(got[31:24]), 255);
        chk("R6 green saturates", int'(got[39:32]), 255);

        // R11: transparent black near passes far unchanged
        run_one(VECS[3], got, lat_ok);
        chk("R11 pass-through", int'(got[47:16]), int'({8'h33, 8'h22, 8'h11, 8'h7F}));

        // R7: coverage above 16 behaves as 16
        v = VECS[2];
        v.cov = 5'd16;
        run_one(v, got, lat_ok);
        v.cov = 5'd31;
        run_one(v, got2, lat_ok);
        chk("R7 cover 31 equals 16", int'(got2 == got), 1);
        v.cov = 5'd17;
        run_one(v, got2, lat_ok);
        chk("R7 cover 17 equals 16", int'(got2 == got), 1);

        // R9: loads six cycles apart give a gapless stream
        begin
            logic [95:0] stream;
            int nvalid, nfirst;
            nvalid = 0; nfirst = 0;
            @(negedge clk); apply(VECS[2]);
            @(negedge clk); in_load = 1'b0;
            repeat (5) @(negedge clk);
            apply(VECS[4]);
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (i == 0) in_load = 1'b0;
                stream[8*i +: 8] = out_byte;
                if (out_valid) nvalid++;
                if (out_first) nfirst++;
            end
            chk("R9 valid cycles", nvalid, 12);
            chk("R9 markers", nfirst, 2);
            chk("R9 first result", int'(stream[47:0] == model(VECS[2])), 1);
            chk("R9 second result", int'(stream[95:48] == model(VECS[4])), 1);
            @(negedge clk);
            chk("R9 stream ends", int'(out_valid), 0);
            repeat (3) @(negedge clk);
        end

        // R10: a load three cycles into a slot is ignored
        begin
            int nvalid;
            nvalid = 0;
            @(negedge clk); apply(VECS[0]);
            @(negedge clk); in_load = 1'b0;
            @(negedge clk);
            @(negedge clk); apply(VECS[6]);
            @(negedge clk); in_load = 1'b0;
            repeat (2) @(negedge clk);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                got[8*i +: 8] = out_byte;
                if (out_valid) nvalid++;
            end
            chk("R10 result unchanged", int'(got == model(VECS[0])), 1);
            chk("R10 six bytes", nvalid, 6);
            repeat (8) @(negedge clk);
            chk("R10 no extra result", int'(out_valid), 0);
        end

        done = 1'b1;
        summary();
    end
endmodule